// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block stands in for a parallel NOR flash that speaks the common block-erase command set. A host issues byte-wide command codes on the low data lane, and the block tracks the multi-cycle sequences they open. It keeps a small byte array as the flash contents, a status byte, and a read-mode selector that picks what a bus read returns: array data, status, identifier codes or the query table.

The bus is a plain synchronous strobe port. Every read or write strobe is taken in the cycle it is raised, and there is no stall and no back-pressure. A write updates storage at the same clock edge that accepts it. A read is registered, so its data and a one-cycle valid flag appear one cycle after the strobe. The bus carries `BUS_BYTES` bytes, little-endian, and is made of `BUS_BYTES/DEV_BYTES` device lanes. A read-only input blocks every change to storage and raises the matching error bit instead.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, a read returns the erased array (every byte 0xFF), the sequencer is in array mode, and the status byte is 0x80.
- R2: In the idle phase, a write of 0x10 or 0x40 opens a program. The next write stores its full bus word little-endian at the bus-aligned address, sets status bit 7 (0x80, ready) and returns to the idle phase. Reads then return status until array mode is selected again.
- R3: In the idle phase, a write of 0x20 fills every byte of the SECT_LEN-aligned block that holds the address with 0xFF, leaves other blocks alone and sets ready. A following 0xD0 confirms and leaves the block in status-read mode. A following 0xFF, or any other value, returns to array mode.
- R4: While read_only is high, no program or erase changes storage. A refused program sets status bit 4 (0x10) and a refused erase sets bit 5 (0x20), each together with ready. The error bits stay set until they are cleared.
- R5: In the idle phase, a write of 0x50 clears the whole status byte to 0x00 and selects array mode.
- R6: A write of 0x70 selects status-read mode without opening a sequence. A status read places the status byte, zero-extended, into each device lane.
- R7: A write of 0xE8 sets ready and opens a buffered write. The next write is a count, masked to the low DEV_BYTES*8 bits. Each data write stores its word and decrements the count. The data write that finds the count at zero moves to a confirm phase, where 0xD0 finishes in status mode and any other value aborts to array mode.
- R8: A write of 0x60 opens a lock sequence. A second write of 0xD0 or 0x01 completes it with ready set. Any other second value returns to array mode.
- R9: A write of 0x90 selects identifier mode. At word offset (address / BUS_BYTES) 0 each lane reads the maker code, at offset 1 the part code, and at every other offset zero.
- R10: A write of 0x98 selects query mode. At word offsets 0x10, 0x11, 0x12 and 0x13 each lane reads 0x51, 0x52, 0x59 and 0x01, and zero elsewhere. Writes other than 0xFF keep query mode.
- R11: In the idle phase, 0xFF, 0xF0, 0x00 and any code not listed above select array mode with the phase cleared.
- R12: rvalid is high in exactly the cycle after each read strobe, and rdata then holds the result for the state that the sequencer had when the strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, taken every cycle it is high |
| wr_en | input | 1 | Write strobe, taken every cycle it is high |
| addr | input | ADDR_W | Byte address |
| wdata | input | BUS_BYTES*8 | Write data; command codes on bits 7:0 |
| read_only | input | 1 | Blocks storage changes when high |
| rdata | output | BUS_BYTES*8 | Registered read data |
| rvalid | output | 1 | High one cycle after a read strobe |

## Verification
The bench sweeps every idle-phase command byte whose effect does not touch storage and compares the next read against array, status, identifier or query expectations. A decoder that sent an unknown code into a sequence would return status where array data belongs. The buffered write is given a count with a stray upper byte. A design that did not mask it would treat the confirm code as data and never leave the data phase. Erase is checked next to a programmed neighbour block, which catches wrong alignment, and the read-only runs show whether storage moved or the error bits were dropped. Aborts by 0xFF and by unknown second codes are checked against the reads that follow, because a design that stayed in the sequence would return status instead of array data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] OP_NULL      = 8'h00;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_CLEAR     = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_BUFFER    = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;
  localparam logic [7:0] OP_ARRAY     = 8'hFF;
  localparam logic [7:0] OP_ARRAY_ALT = 8'hF0;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  typedef enum logic [1:0] {
    PH_IDLE, PH_ARG, PH_DATA, PH_CONFIRM
  } phase_t;

  typedef enum logic [2:0] {
    M_ARRAY, M_PROG, M_ERASE, M_LOCK, M_STAT, M_IDENT, M_QUERY, M_BUF
  } mode_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [7:0]       op_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ro_i,
  output logic             prog_o,
  output logic             erase_o,
  output logic [7:0]       status_o,
  output mode_t            mode_o
);

  phase_t           ph_q, ph_n;
  mode_t            mode_q, mode_n;
  logic [7:0]       stat_q, stat_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    ph_n    = ph_q;
    mode_n  = mode_q;
    stat_n  = stat_q;
    cnt_n   = cnt_q;
    prog_o  = 1'b0;
    erase_o = 1'b0;
    if (wr_i) begin
      unique case (ph_q)
        PH_IDLE: begin
          case (op_i)
            OP_PROG_A, OP_PROG_B: begin
              mode_n = M_PROG;
              ph_n   = PH_ARG;
            end
            OP_ERASE: begin
              erase_o = !ro_i;
              if (ro_i) stat_n = stat_n | ST_ERASE_ERR;
              stat_n = stat_n | ST_READY;
              mode_n = M_ERASE;
              ph_n   = PH_ARG;
            end
            OP_CLEAR: begin
              stat_n = 8'h00;
              mode_n = M_ARRAY;
            end
            OP_LOCK: begin
              mode_n = M_LOCK;
              ph_n   = PH_ARG;
            end
            OP_STATUS: mode_n = M_STAT;
            OP_IDENT:  mode_n = M_IDENT;
            OP_QUERY: begin
              mode_n = M_QUERY;
              ph_n   = PH_ARG;
            end
            OP_BUFFER: begin
              stat_n = stat_n | ST_READY;
              mode_n = M_BUF;
              ph_n   = PH_ARG;
            end
            default: begin
              mode_n = M_ARRAY;
              ph_n   = PH_IDLE;
            end
          endcase
        end
        PH_ARG: begin
          case (mode_q)
            M_PROG: begin
              prog_o = !ro_i;
              if (ro_i) stat_n = stat_n | ST_PROG_ERR;
              stat_n = stat_n | ST_READY;
              ph_n   = PH_IDLE;
            end
            M_ERASE: begin
              ph_n = PH_IDLE;
              if (op_i == OP_CONFIRM) stat_n = stat_n | ST_READY;
              else mode_n = M_ARRAY;
            end
            M_BUF: begin
              cnt_n = cnt_i;
              ph_n  = PH_DATA;
            end
            M_LOCK: begin
              ph_n = PH_IDLE;
              if (op_i == OP_CONFIRM || op_i == OP_LOCK_ALT) stat_n = stat_n | ST_READY;
              else mode_n = M_ARRAY;
            end
            M_QUERY: begin
              if (op_i == OP_ARRAY) begin
                mode_n = M_ARRAY;
                ph_n   = PH_IDLE;
              end
            end
            default: begin
              mode_n = M_ARRAY;
              ph_n   = PH_IDLE;
            end
          endcase
        end
        PH_DATA: begin
          if (mode_q == M_BUF) begin
            prog_o = !ro_i;
            if (ro_i) stat_n = stat_n | ST_PROG_ERR;
            stat_n = stat_n | ST_READY;
            if (cnt_q == '0) ph_n = PH_CONFIRM;
            cnt_n = cnt_q - 1'b1;
          end else begin
            mode_n = M_ARRAY;
            ph_n   = PH_IDLE;
          end
        end
        PH_CONFIRM: begin
          ph_n = PH_IDLE;
          if (mode_q == M_BUF && op_i == OP_CONFIRM) stat_n = stat_n | ST_READY;
          else mode_n = M_ARRAY;
        end
        default: begin
          mode_n = M_ARRAY;
          ph_n   = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      mode_q <= M_ARRAY;
      stat_q <= ST_READY;
      cnt_q  <= '0;
    end else begin
      ph_q   <= ph_n;
      mode_q <= mode_n;
      stat_q <= stat_n;
      cnt_q  <= cnt_n;
    end
  end

  assign status_o = stat_q;
  assign mode_o   = mode_q;

  p_ready_after_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ph_q == PH_IDLE && op_i == OP_ERASE) |=> stat_q[7]);

  p_clear_to_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ph_q == PH_IDLE && op_i == OP_CLEAR) |=> (stat_q == 8'h00 && mode_q == M_ARRAY));

  p_data_phase_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA || ph_q == PH_CONFIRM) |-> mode_q == M_BUF);

  p_prog_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[4] && !(wr_i && ph_q == PH_IDLE && op_i == OP_CLEAR)) |=> stat_q[4]);

endmodule

// File: rtl/flash_seq_store.sv
module flash_seq_store #(
  parameter int ADDR_W    = 6,
  parameter int BUS_BYTES = 2,
  parameter int SECT_LEN  = 16,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int BUS_W    = BUS_BYTES * 8,
  localparam int SECT_SH  = $clog2(SECT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              ro_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  word_o
);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] base;

  assign base = addr_i & ~ADDR_W'(BUS_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++)
        if ((ADDR_W'(i) >> SECT_SH) == (addr_i >> SECT_SH)) mem_q[i] <= 8'hFF;
    end else if (prog_i) begin
      for (int b = 0; b < BUS_BYTES; b++)
        mem_q[base + ADDR_W'(b)] <= wdata_i[8*b +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < BUS_BYTES; b++)
      word_o[8*b +: 8] = mem_q[base + ADDR_W'(b)];
  end

  p_ro_blocks_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ro_i && (prog_i || erase_i)));

  p_single_store_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_i && erase_i));

endmodule

// File: rtl/flash_seq_rdmux.sv
module flash_seq_rdmux
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BUS_BYTES    = 2,
  parameter int DEV_BYTES    = 1,
  parameter int unsigned MAKER_CODE = 'h89,
  parameter int unsigned PART_CODE  = 'h18,
  localparam int BUS_W = BUS_BYTES * 8,
  localparam int DEV_W = DEV_BYTES * 8,
  localparam int LANES = BUS_BYTES / DEV_BYTES,
  localparam int WSH   = $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mode_t             mode_i,
  input  logic [7:0]        status_i,
  input  logic [BUS_W-1:0]  word_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] woff;
  logic [DEV_W-1:0]  id_lane, qry_lane, st_lane;
  logic [BUS_W-1:0]  id_word, qry_word, st_word, sel;

  assign woff = addr_i >> WSH;

  always_comb begin
    case (int'(woff))
      0:       id_lane = DEV_W'(MAKER_CODE);
      1:       id_lane = DEV_W'(PART_CODE);
      default: id_lane = '0;
    endcase
    case (int'(woff))
      'h10:    qry_lane = DEV_W'(8'h51);
      'h11:    qry_lane = DEV_W'(8'h52);
      'h12:    qry_lane = DEV_W'(8'h59);
      'h13:    qry_lane = DEV_W'(8'h01);
      default: qry_lane = '0;
    endcase
    st_lane = DEV_W'(status_i);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign id_word[l*DEV_W +: DEV_W]  = id_lane;
    assign qry_word[l*DEV_W +: DEV_W] = qry_lane;
    assign st_word[l*DEV_W +: DEV_W]  = st_lane;
  end

  always_comb begin
    case (mode_i)
      M_ARRAY: sel = word_i;
      M_IDENT: sel = id_word;
      M_QUERY: sel = qry_word;
      default: sel = st_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= sel;
    end
  end

  p_rvalid_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);

  p_rvalid_only_after_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUS_BYTES = 2,
  parameter int DEV_BYTES = 1,
  parameter int SECT_LEN  = 16,
  parameter int unsigned MAKER_CODE = 'h89,
  parameter int unsigned PART_CODE  = 'h18,
  localparam int BUS_W = BUS_BYTES * 8,
  localparam int DEV_W = DEV_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              read_only,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid
);

  logic             prog, erase;
  logic [7:0]       status;
  mode_t            mode;
  logic [BUS_W-1:0] word;

  flash_seq_ctrl #(.CNT_W(DEV_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en),
    .op_i     (wdata[7:0]),
    .cnt_i    (wdata[DEV_W-1:0]),
    .ro_i     (read_only),
    .prog_o   (prog),
    .erase_o  (erase),
    .status_o (status),
    .mode_o   (mode)
  );

  flash_seq_store #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .SECT_LEN  (SECT_LEN)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_i  (prog),
    .erase_i (erase),
    .ro_i    (read_only),
    .addr_i  (addr),
    .wdata_i (wdata),
    .word_o  (word)
  );

  flash_seq_rdmux #(
    .ADDR_W     (ADDR_W),
    .BUS_BYTES  (BUS_BYTES),
    .DEV_BYTES  (DEV_BYTES),
    .MAKER_CODE (MAKER_CODE),
    .PART_CODE  (PART_CODE)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_en),
    .addr_i   (addr),
    .mode_i   (mode),
    .status_i (status),
    .word_i   (word),
    .rdata_o  (rdata),
    .rvalid_o (rvalid)
  );

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        read_only = 1'b0;
  logic [15:0] rdata;
  logic        rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mem_m [64];
  logic [7:0] stat_m;

  always #2.5 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .read_only(read_only), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    if (!rvalid) begin
      checks++; errors++;
      $display("FAIL R12 actual=rvalid 0 expected=rvalid 1");
    end
  endtask

  function automatic logic [15:0] arr(input logic [5:0] a);
    logic [5:0] b = {a[5:1], 1'b0};
    return {mem_m[b + 6'd1], mem_m[b]};
  endfunction

  function automatic logic [15:0] st2();
    return {stat_m, stat_m};
  endfunction

  task automatic m_prog(input logic [5:0] a, input logic [15:0] d);
    if (!read_only) begin
      mem_m[{a[5:1], 1'b0}] = d[7:0];
      mem_m[{a[5:1], 1'b1}] = d[15:8];
    end else stat_m = stat_m | 8'h10;
    stat_m = stat_m | 8'h80;
  endtask

  task automatic m_erase(input logic [5:0] a);
    if (!read_only) begin
      for (int i = 0; i < 64; i++) if (i / 16 == a / 16) mem_m[i] = 8'hFF;
    end else stat_m = stat_m | 8'h20;
    stat_m = stat_m | 8'h80;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 64; i++) mem_m[i] = 8'hFF;
    stat_m = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_rd(6'h00, d); check("R1 erased array", d, 16'hFFFF);
    bus_rd(6'h3E, d); check("R1 erased array top", d, 16'hFFFF);
    // R12: rvalid drops the cycle after
    @(negedge clk); checks++;
    if (rvalid !== 1'b0) begin errors++; $display("FAIL R12 actual=%b expected=0", rvalid); end
    bus_wr(6'h00, 16'h0070);
    bus_rd(6'h00, d); check("R1 R6 status after reset", d, 16'h8080);
    bus_wr(6'h00, 16'h00FF);

    // R2: program with both opcodes
    bus_wr(6'h04, 16'h0040); bus_wr(6'h04, 16'h1234); m_prog(6'h04, 16'h1234);
    bus_rd(6'h04, d); check("R2 status after program", d, st2());
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h04, d); check("R2 programmed word", d, arr(6'h04));
    bus_wr(6'h0B, 16'h0010); bus_wr(6'h0B, 16'hBEEF); m_prog(6'h0B, 16'hBEEF);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h0A, d); check("R2 program aligned", d, 16'hBEEF);
    bus_wr(6'h12, 16'h0010); bus_wr(6'h12, 16'h5AA5); m_prog(6'h12, 16'h5AA5);
    bus_wr(6'h00, 16'h00FF);

    // R5: clear status
    bus_wr(6'h00, 16'h0050); stat_m = 8'h00;
    bus_rd(6'h04, d); check("R5 clear goes to array", d, arr(6'h04));
    bus_wr(6'h00, 16'h0070);
    bus_rd(6'h00, d); check("R5 status cleared", d, 16'h0000);
    bus_wr(6'h00, 16'h00FF);

    // R3: erase block 0 with confirm; block 1 untouched
    bus_wr(6'h05, 16'h0020); m_erase(6'h05);
    bus_wr(6'h05, 16'h00D0);
    bus_rd(6'h00, d); check("R3 status after confirm", d, st2());
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h04, d); check("R3 erased word", d, 16'hFFFF);
    bus_rd(6'h0A, d); check("R3 erased word 2", d, 16'hFFFF);
    bus_rd(6'h12, d); check("R3 neighbour block kept", d, 16'h5AA5);
    bus_wr(6'h08, 16'h0010); bus_wr(6'h08, 16'h7788); m_prog(6'h08, 16'h7788);
    bus_wr(6'h00, 16'h0020); m_erase(6'h00);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h08, d); check("R3 abort to array", d, 16'hFFFF);
    bus_wr(6'h00, 16'h0020); m_erase(6'h00);
    bus_wr(6'h00, 16'h0033);
    bus_rd(6'h12, d); check("R3 unknown second code to array", d, 16'h5AA5);

    // R4: read-only refusal
    bus_wr(6'h00, 16'h0050); stat_m = 8'h00;
    read_only = 1'b1;
    bus_wr(6'h12, 16'h0010); bus_wr(6'h12, 16'h0000); m_prog(6'h12, 16'h0000);
    bus_rd(6'h12, d); check("R4 program error status", d, 16'h9090);
    bus_wr(6'h12, 16'h0020); m_erase(6'h12);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h12, d); check("R4 storage unchanged", d, 16'h5AA5);
    bus_wr(6'h00, 16'h0070);
    bus_rd(6'h00, d); check("R4 both error bits", d, 16'hB0B0);
    read_only = 1'b0;
    bus_wr(6'h00, 16'h00FF);
    bus_wr(6'h00, 16'h0010); bus_wr(6'h00, 16'h0102); m_prog(6'h00, 16'h0102);
    bus_rd(6'h00, d); check("R4 error bits sticky", d, 16'hB0B0);
    bus_wr(6'h00, 16'h0050); stat_m = 8'h00;

    // R7: buffered write with masked count (0x0102 -> 2)
    bus_wr(6'h30, 16'h00E8); stat_m = stat_m | 8'h80;
    bus_wr(6'h30, 16'h0102);
    bus_wr(6'h30, 16'h1111); m_prog(6'h30, 16'h1111);
    bus_wr(6'h32, 16'h2222); m_prog(6'h32, 16'h2222);
    bus_wr(6'h34, 16'h3333); m_prog(6'h34, 16'h3333);
    bus_wr(6'h30, 16'h00D0);
    bus_rd(6'h30, d); check("R7 confirm gives status", d, st2());
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h30, d); check("R7 buffer word 0", d, 16'h1111);
    bus_rd(6'h32, d); check("R7 buffer word 1", d, 16'h2222);
    bus_rd(6'h34, d); check("R7 buffer word 2", d, 16'h3333);
    bus_wr(6'h38, 16'h00E8);
    bus_wr(6'h38, 16'h0000);
    bus_wr(6'h38, 16'h4444); m_prog(6'h38, 16'h4444);
    bus_wr(6'h38, 16'h0000);
    bus_rd(6'h38, d); check("R7 bad confirm aborts to array", d, 16'h4444);

    // R8: lock sequences
    bus_wr(6'h00, 16'h0060); bus_wr(6'h00, 16'h00D0);
    bus_rd(6'h30, d); check("R8 lock D0 status", d, st2());
    bus_wr(6'h00, 16'h00FF);
    bus_wr(6'h00, 16'h0060); bus_wr(6'h00, 16'h0001);
    bus_rd(6'h30, d); check("R8 lock 01 status", d, st2());
    bus_wr(6'h00, 16'h00FF);
    bus_wr(6'h00, 16'h0060); bus_wr(6'h00, 16'h0033);
    bus_rd(6'h30, d); check("R8 lock bad code to array", d, 16'h1111);

    // R9: identifier
    bus_wr(6'h00, 16'h0090);
    bus_rd(6'h00, d); check("R9 maker code", d, 16'h8989);
    bus_rd(6'h02, d); check("R9 part code", d, 16'h1818);
    bus_rd(6'h04, d); check("R9 other offset", d, 16'h0000);
    bus_wr(6'h00, 16'h00FF);

    // R10: query
    bus_wr(6'h00, 16'h0098);
    bus_rd(6'h20, d); check("R10 query Q", d, 16'h5151);
    bus_wr(6'h00, 16'h0000);
    bus_rd(6'h22, d); check("R10 stays in query", d, 16'h5252);
    bus_rd(6'h24, d); check("R10 query Y", d, 16'h5959);
    bus_rd(6'h26, d); check("R10 query cmdset", d, 16'h0101);
    bus_rd(6'h10, d); check("R10 query zero", d, 16'h0000);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h30, d); check("R10 R11 leave query", d, 16'h1111);

    // R11 R6 R9 R10: sweep of idle-phase codes
    for (int c = 0; c < 256; c++) begin
      logic [15:0] e;
      if (c == 'h10 || c == 'h40 || c == 'h20 || c == 'hE8 || c == 'h50) continue;
      bus_wr(6'h30, 16'(c));
      case (c)
        'h60, 'h70: e = st2();
        'h90:       e = 16'h0000;
        'h98:       e = 16'h5151;
        default:    e = arr(6'h20);
      endcase
      bus_rd(6'h20, d);
      check($sformatf("R11 sweep code %02h", c), d, e);
      bus_wr(6'h30, 16'h00FF);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule